// File: doc/BRIEF.md
# Bus-Controlled Fault Injection Sequencer

This block lets a host program saboteur scan chains without toggling each bit in software. The host writes a set of configuration words, a chain length, an activation mode and a delay count into memory-mapped registers through a Wishbone B4 slave port. It then sets a start bit. A state machine streams the configuration serially into the scan chains of several accelerator cores at the same time. When the last bit has gone out, it raises the fault activation line of every core together.

Activation can follow the shift at once, or it can wait a programmed number of cycles. The host polls a status register for a busy flag and a done flag. Writing the done flag back acknowledges the run. This drops activation and readies the block for the next run. Because the length is a register, one instance can serve chains of any length up to the storage it holds. All cores receive the same pattern.

Top module: `fault_seq_top`

## Requirements
- R1: Every bus access with CYC and STB both high is acknowledged by ACK high in the following cycle, for that one cycle only. A read returns the stored value of the addressed register. Byte addresses: control 0x00, length 0x04, delay 0x08, status 0x0C, configuration word i at 0x10 + 4*i.
- R2: A length write larger than the configuration storage (NWORDS*32 bits) stores the storage size instead.
- R3: A start is a control write with bit 0 set. When it is accepted, scan enable is high for exactly length cycles, starting in the cycle after the edge that raises ACK. Bit k of the stream is bit k%32 of configuration word k/32, so word 0 bit 0 goes first. The scan data output is 0 whenever scan enable is low.
- R4: The scan data outputs of all cores carry the same bit in every cycle, and the activation outputs of all cores are always equal.
- R5: In immediate mode (control bit 1 written 0 with the start), activation rises in the cycle right after the last shift cycle.
- R6: In delayed mode (control bit 1 written 1 with the start), activation rises a number of cycles after that point equal to the delay register. A delay of 0 behaves as immediate mode.
- R7: Status bit 0 (busy) is 1 from the start until activation rises. Status bit 1 (done) is then 1, and activation stays high until the run is cleared. Both flags and all outputs are 0 after reset.
- R8: Writing status with bit 1 set while done returns the block to idle. Activation falls in the cycle after the edge that accepts the write, and status reads 0.
- R9: While busy, writes to control, length, delay and configuration words have no effect: a new start is not taken and the stored values read back unchanged.
- R10: With length 0, no shift cycle occurs and the delay phase (if any) begins at once. In immediate mode, activation rises in the cycle after the start is accepted.
- R11: While done, a start write is ignored: no shift occurs, activation stays high and done stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wb_cyc_i | input | 1 | Bus cycle valid |
| wb_stb_i | input | 1 | Bus strobe |
| wb_we_i | input | 1 | Write enable |
| wb_adr_i | input | ADR_W | Byte address |
| wb_dat_i | input | 32 | Write data |
| wb_dat_o | output | 32 | Read data |
| wb_ack_o | output | 1 | Acknowledge |
| scan_en_o | output | 1 | Scan shift enable shared by all chains |
| scan_do_o | output | NCORES | Serial configuration data, one per core chain |
| fault_act_o | output | NCORES | Fault activation, one per core |

## Verification
A cycle-accurate model in the bench predicts scan enable, the serial bit and activation for every clock, and compares all cores each cycle. Runs use two different word patterns, lengths of 40, 33, 3, 0 and the full 128 bits, and delays of 0, 4 and 7. This covers bit order across word boundaries, the exact count of shift cycles, and the gap between the last bit and activation. The mid-run writes and the start written while done show whether the busy and done gating hold. If they fail, the model sees extra shift cycles or altered readback.

// File: rtl/fault_seq_pkg.sv
package fault_seq_pkg;

  localparam int WORD_W = 32;

  // word indices of the register map (byte address / 4)
  localparam int IDX_CTRL = 0;
  localparam int IDX_LEN  = 1;
  localparam int IDX_DLY  = 2;
  localparam int IDX_STAT = 3;
  localparam int IDX_CFG0 = 4;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SHIFT  = 3'd1,
    ST_WAIT   = 3'd2,
    ST_ACTIVE = 3'd3,
    ST_DONE   = 3'd4
  } seq_state_t;

endpackage

// File: rtl/fault_seq_regs.sv
module fault_seq_regs
  import fault_seq_pkg::*;
#(
  parameter int NWORDS  = 4,
  parameter int ADR_W   = 5,
  parameter int DLY_W   = 16,
  parameter int MAX_LEN = NWORDS * WORD_W,
  parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
  input  logic                     clk,
  input  logic                     rst_ni,
  input  logic                     wb_cyc_i,
  input  logic                     wb_stb_i,
  input  logic                     wb_we_i,
  input  logic [ADR_W-1:0]         wb_adr_i,
  input  logic [WORD_W-1:0]        wb_dat_i,
  output logic [WORD_W-1:0]        wb_dat_o,
  output logic                     wb_ack_o,
  input  logic                     busy_i,
  input  logic                     done_i,
  output logic [MAX_LEN-1:0]       cfg_o,
  output logic [LEN_W-1:0]         len_o,
  output logic [DLY_W-1:0]         dly_o,
  output logic                     mode_o,
  output logic                     start_o,
  output logic                     clear_o
);

  localparam int IW = ADR_W - 2;

  logic              ack_q;
  logic [WORD_W-1:0] dat_q, rdata;
  logic              req, wr, open_wr;
  logic [IW-1:0]     widx;
  logic [LEN_W-1:0]  len_q, len_d;
  logic [DLY_W-1:0]  dly_q;
  logic              mode_q;
  logic [WORD_W-1:0] cfg_q [NWORDS];
  logic              wr_ctrl, wr_len, wr_dly;
  logic [NWORDS-1:0] wr_cfg;
  logic              unused_adr;

  assign unused_adr = ^wb_adr_i[1:0];
  assign req     = wb_cyc_i & wb_stb_i & ~ack_q;
  assign wr      = req & wb_we_i;
  assign open_wr = wr & ~busy_i;
  assign widx    = wb_adr_i[ADR_W-1:2];

  assign wr_ctrl = open_wr & (widx == IW'(IDX_CTRL));
  assign wr_len  = open_wr & (widx == IW'(IDX_LEN));
  assign wr_dly  = open_wr & (widx == IW'(IDX_DLY));

  always_comb begin
    if (wb_dat_i > WORD_W'(MAX_LEN)) len_d = LEN_W'(MAX_LEN);
    else                             len_d = wb_dat_i[LEN_W-1:0];
  end

  // read mux
  always_comb begin
    rdata = '0;
    if (widx == IW'(IDX_CTRL))      rdata = {{(WORD_W-2){1'b0}}, mode_q, 1'b0};
    else if (widx == IW'(IDX_LEN))  rdata = WORD_W'(len_q);
    else if (widx == IW'(IDX_DLY))  rdata = WORD_W'(dly_q);
    else if (widx == IW'(IDX_STAT)) rdata = {{(WORD_W-2){1'b0}}, done_i, busy_i};
    for (int w = 0; w < NWORDS; w++) begin
      if (widx == IW'(IDX_CFG0 + w)) rdata = cfg_q[w];
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q <= 1'b0;
      dat_q <= '0;
    end else begin
      ack_q <= req;
      if (req) dat_q <= rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q  <= '0;
      dly_q  <= '0;
      mode_q <= 1'b0;
    end else begin
      if (wr_len)  len_q  <= len_d;
      if (wr_dly)  dly_q  <= wb_dat_i[DLY_W-1:0];
      if (wr_ctrl) mode_q <= wb_dat_i[1];
    end
  end

  for (genvar g = 0; g < NWORDS; g++) begin : g_cfg
    assign wr_cfg[g] = open_wr & (widx == IW'(IDX_CFG0 + g));
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni)        cfg_q[g] <= '0;
      else if (wr_cfg[g]) cfg_q[g] <= wb_dat_i;
    end
    assign cfg_o[g*WORD_W +: WORD_W] = cfg_q[g];
  end

  assign wb_ack_o = ack_q;
  assign wb_dat_o = dat_q;
  assign len_o    = len_q;
  assign dly_o    = dly_q;
  assign mode_o   = wr_ctrl ? wb_dat_i[1] : mode_q;
  assign start_o  = wr_ctrl & wb_dat_i[0];
  assign clear_o  = wr & (widx == IW'(IDX_STAT)) & wb_dat_i[1];

  // R1
  ack_next_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (wb_cyc_i && wb_stb_i && !wb_ack_o) |=> wb_ack_o);

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    busy_i |=> ($stable(len_q) && $stable(dly_q) && $stable(mode_q) && $stable(cfg_o)));

endmodule

// File: rtl/fault_seq_fsm.sv
module fault_seq_fsm
  import fault_seq_pkg::*;
#(
  parameter int MAX_LEN = 128,
  parameter int DLY_W   = 16,
  parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
  input  logic               clk,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               clear_i,
  input  logic               mode_i,
  input  logic [LEN_W-1:0]   len_i,
  input  logic [DLY_W-1:0]   dly_i,
  input  logic [MAX_LEN-1:0] cfg_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               shift_en_o,
  output logic               shift_bit_o,
  output logic               act_o
);

  localparam int IDX_W = $clog2(MAX_LEN);

  seq_state_t       state_q, state_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic [DLY_W-1:0] dcnt_q, dcnt_d;
  logic             mode_q, mode_d;
  logic             last_bit;

  assign last_bit = (cnt_q == len_i - 1'b1);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    dcnt_d  = dcnt_q;
    mode_d  = mode_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          cnt_d  = '0;
          dcnt_d = dly_i;
          mode_d = mode_i;
          if (len_i != '0)                   state_d = ST_SHIFT;
          else if (mode_i && dly_i != '0)    state_d = ST_WAIT;
          else                               state_d = ST_ACTIVE;
        end
      end
      ST_SHIFT: begin
        cnt_d = cnt_q + 1'b1;
        if (last_bit) begin
          if (mode_q && dcnt_q != '0) state_d = ST_WAIT;
          else                        state_d = ST_ACTIVE;
        end
      end
      ST_WAIT: begin
        dcnt_d = dcnt_q - 1'b1;
        if (dcnt_q == DLY_W'(1)) state_d = ST_ACTIVE;
      end
      ST_ACTIVE: state_d = ST_DONE;
      ST_DONE:   if (clear_i) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      dcnt_q  <= '0;
      mode_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      dcnt_q  <= dcnt_d;
      mode_q  <= mode_d;
    end
  end

  assign shift_en_o  = (state_q == ST_SHIFT);
  assign shift_bit_o = shift_en_o & cfg_i[cnt_q[IDX_W-1:0]];
  assign act_o       = (state_q == ST_ACTIVE) || (state_q == ST_DONE);
  assign busy_o      = (state_q == ST_SHIFT) || (state_q == ST_WAIT) || (state_q == ST_ACTIVE);
  assign done_o      = (state_q == ST_DONE);

  // R3
  shift_range_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    shift_en_o |-> (cnt_q < len_i));

  // R5
  imm_act_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_SHIFT && last_bit && !mode_q) |=> act_o);

  // R6
  wait_count_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_WAIT) |=> ((state_q == ST_WAIT && dcnt_q == $past(dcnt_q) - 1'b1)
                              || state_q == ST_ACTIVE));

  // R8
  clear_drop_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_DONE && clear_i) |=> !act_o);

  // R11
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_DONE && !clear_i) |=> (done_o && !shift_en_o));

endmodule

// File: rtl/fault_seq_drive.sv
module fault_seq_drive #(
  parameter int NCORES = 4
) (
  input  logic              shift_bit_i,
  input  logic              act_i,
  output logic [NCORES-1:0] scan_do_o,
  output logic [NCORES-1:0] fault_act_o
);

  for (genvar c = 0; c < NCORES; c++) begin : g_core
    assign scan_do_o[c]   = shift_bit_i;
    assign fault_act_o[c] = act_i;
  end

endmodule

// File: rtl/fault_seq_top.sv
module fault_seq_top
  import fault_seq_pkg::*;
#(
  parameter int NWORDS = 4,
  parameter int NCORES = 4,
  parameter int DLY_W  = 16,
  parameter int ADR_W  = $clog2((IDX_CFG0 + NWORDS) * 4)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wb_cyc_i,
  input  logic              wb_stb_i,
  input  logic              wb_we_i,
  input  logic [ADR_W-1:0]  wb_adr_i,
  input  logic [31:0]       wb_dat_i,
  output logic [31:0]       wb_dat_o,
  output logic              wb_ack_o,
  output logic              scan_en_o,
  output logic [NCORES-1:0] scan_do_o,
  output logic [NCORES-1:0] fault_act_o
);

  localparam int MAX_LEN = NWORDS * WORD_W;
  localparam int LEN_W   = $clog2(MAX_LEN + 1);

  logic               rst_s1, rst_s2;
  logic               busy, done, start, clear, mode;
  logic               shift_bit, act;
  logic [MAX_LEN-1:0] cfg;
  logic [LEN_W-1:0]   len;
  logic [DLY_W-1:0]   dly;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  fault_seq_regs #(
    .NWORDS(NWORDS), .ADR_W(ADR_W), .DLY_W(DLY_W), .MAX_LEN(MAX_LEN), .LEN_W(LEN_W)
  ) u_regs (
    .clk(clk), .rst_ni(rst_s2),
    .wb_cyc_i(wb_cyc_i), .wb_stb_i(wb_stb_i), .wb_we_i(wb_we_i),
    .wb_adr_i(wb_adr_i), .wb_dat_i(wb_dat_i), .wb_dat_o(wb_dat_o), .wb_ack_o(wb_ack_o),
    .busy_i(busy), .done_i(done),
    .cfg_o(cfg), .len_o(len), .dly_o(dly), .mode_o(mode),
    .start_o(start), .clear_o(clear)
  );

  fault_seq_fsm #(
    .MAX_LEN(MAX_LEN), .DLY_W(DLY_W), .LEN_W(LEN_W)
  ) u_fsm (
    .clk(clk), .rst_ni(rst_s2),
    .start_i(start), .clear_i(clear), .mode_i(mode),
    .len_i(len), .dly_i(dly), .cfg_i(cfg),
    .busy_o(busy), .done_o(done),
    .shift_en_o(scan_en_o), .shift_bit_o(shift_bit), .act_o(act)
  );

  fault_seq_drive #(.NCORES(NCORES)) u_drive (
    .shift_bit_i(shift_bit), .act_i(act),
    .scan_do_o(scan_do_o), .fault_act_o(fault_act_o)
  );

endmodule

// File: tb/fault_seq_top_bench.sv
module fault_seq_top_bench;

  localparam int NW  = 4;
  localparam int NC  = 4;
  localparam int AW  = 5;
  localparam int MAX = NW * 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cyc = 1'b0, stb = 1'b0, we = 1'b0;
  logic [AW-1:0] adr = '0;
  logic [31:0]   wdat = '0;
  logic [31:0]   rdat;
  logic          ack, sen;
  logic [NC-1:0] sdo, fact;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;

  // reference model state
  logic [2:0] exp_q[$];   // {en, bit, act}
  logic       act_tail = 1'b0;
  logic       m_idle = 1'b1;
  logic       run_chk = 1'b0;
  logic [31:0] cfg_m [NW];
  int         len_m = 0;
  int         dly_m = 0;
  string      cur_req = "R3";

  always #10 clk = ~clk;

  fault_seq_top #(.NWORDS(NW), .NCORES(NC), .DLY_W(16)) u_fault_seq_top (
    .clk(clk), .rst_n(rst_n),
    .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we), .wb_adr_i(adr),
    .wb_dat_i(wdat), .wb_dat_o(rdat), .wb_ack_o(ack),
    .scan_en_o(sen), .scan_do_o(sdo), .fault_act_o(fact)
  );

  task automatic check(input logic ok, input string req, input string what,
                       input logic [31:0] act_v, input logic [31:0] exp_v);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act_v, exp_v);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  // per-cycle comparison against the model (R3 R4 R5 R6 R10)
  always @(negedge clk) begin
    if (run_chk) begin
      logic [2:0] e;
      if (exp_q.size() > 0) e = exp_q.pop_front();
      else                  e = {2'b00, act_tail};
      check(sen == e[2], cur_req, "scan_en", 32'(sen), 32'(e[2]));
      check(sdo == {NC{e[1]}}, "R4", "scan_do all cores", 32'(sdo), 32'({NC{e[1]}}));
      check(fact == {NC{e[0]}}, cur_req, "fault_act all cores", 32'(fact), 32'({NC{e[0]}}));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      miscompares++;
      $display("FAIL R3 watchdog expired actual=%0d expected=%0d", cycles, 150000);
      summary();
      $finish;
    end
  end

  // hook: 0 none, 1 start, 2 clear
  task automatic bus(input logic w, input logic [AW-1:0] a, input logic [31:0] d,
                     input int hook, output logic [31:0] rd);
    @(negedge clk); #2;
    cyc = 1'b1; stb = 1'b1; we = w; adr = a; wdat = d;
    @(posedge clk);
    if (hook == 1 && m_idle) begin
      m_idle = 1'b0;
      for (int k = 0; k < len_m; k++) exp_q.push_back({1'b1, cfg_m[k/32][k%32], 1'b0});
      if (d[1]) for (int k = 0; k < dly_m; k++) exp_q.push_back(3'b000);
      act_tail = 1'b1;
    end else if (hook == 2) begin
      m_idle = 1'b1;
      act_tail = 1'b0;
    end
    @(negedge clk); #2;
    check(ack == 1'b1, "R1", "ack after request", 32'(ack), 32'd1);
    rd = rdat;
    cyc = 1'b0; stb = 1'b0; we = 1'b0;
    @(negedge clk); #2;
    check(ack == 1'b0, "R1", "ack single cycle", 32'(ack), 32'd0);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input int hook = 0);
    logic [31:0] dummy;
    bus(1'b1, a, d, hook, dummy);
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input logic [31:0] exp_v, input string req);
    logic [31:0] v;
    bus(1'b0, a, 32'd0, 0, v);
    check(v == exp_v, req, "register read", v, exp_v);
  endtask

  task automatic load_cfg(input logic [31:0] seed);
    for (int w = 0; w < NW; w++) begin
      cfg_m[w] = seed ^ (32'h1357_9BDF * (w + 1)) ^ (32'h0F0F_0000 >> w);
      wr(AW'(16 + 4 * w), cfg_m[w]);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(4);
    // R7 reset state
    check(fact == '0, "R7", "fault_act after reset", 32'(fact), 32'd0);
    check(sen == 1'b0, "R7", "scan_en after reset", 32'(sen), 32'd0);
    check(ack == 1'b0, "R1", "ack idle", 32'(ack), 32'd0);
    run_chk = 1'b1;
    rd_chk(5'h0C, 32'd0, "R7");
    rd_chk(5'h04, 32'd0, "R1");

    // R1 readback, R2 saturation
    load_cfg(32'hA5C3_3C5A);
    for (int w = 0; w < NW; w++) rd_chk(AW'(16 + 4 * w), cfg_m[w], "R1");
    wr(5'h04, 32'd200);
    rd_chk(5'h04, 32'(MAX), "R2");
    wr(5'h04, 32'hFFFF_0000);
    rd_chk(5'h04, 32'(MAX), "R2");
    wr(5'h04, 32'd40);  len_m = 40;
    rd_chk(5'h04, 32'd40, "R1");
    wr(5'h08, 32'd7);   dly_m = 7;
    rd_chk(5'h08, 32'd7, "R1");

    // immediate run, writes while busy (R3 R5 R7 R9)
    cur_req = "R5";
    wr(5'h00, 32'd1, 1);
    rd_chk(5'h0C, 32'd1, "R7");
    wr(5'h04, 32'd5);
    wr(5'h10, 32'd0);
    wr(5'h00, 32'd3, 1);
    wait_cyc(45);
    rd_chk(5'h0C, 32'd2, "R7");
    rd_chk(5'h04, 32'd40, "R9");
    rd_chk(5'h10, cfg_m[0], "R9");
    rd_chk(5'h00, 32'd0, "R9");
    // start while done is ignored (R11)
    cur_req = "R11";
    wr(5'h00, 32'd1, 1);
    wait_cyc(5);
    rd_chk(5'h0C, 32'd2, "R11");
    cur_req = "R8";
    wr(5'h0C, 32'd2, 2);
    rd_chk(5'h0C, 32'd0, "R8");

    // delayed run with other pattern (R6)
    load_cfg(32'h6E19_D2B7);
    wr(5'h04, 32'd33); len_m = 33;
    cur_req = "R6";
    wr(5'h00, 32'd3, 1);
    wait_cyc(50);
    rd_chk(5'h00, 32'd2, "R6");
    wr(5'h0C, 32'd2, 2);

    // zero delay in delayed mode (R6)
    wr(5'h08, 32'd0);  dly_m = 0;
    wr(5'h04, 32'd3);  len_m = 3;
    wr(5'h00, 32'd3, 1);
    wait_cyc(8);
    wr(5'h0C, 32'd2, 2);

    // zero length (R10)
    cur_req = "R10";
    wr(5'h04, 32'd0);  len_m = 0;
    wr(5'h00, 32'd1, 1);
    wait_cyc(3);
    rd_chk(5'h0C, 32'd2, "R10");
    wr(5'h0C, 32'd2, 2);
    wr(5'h08, 32'd4);  dly_m = 4;
    wr(5'h00, 32'd3, 1);
    wait_cyc(8);
    wr(5'h0C, 32'd2, 2);

    // full capacity (R3)
    cur_req = "R3";
    wr(5'h04, 32'(MAX)); len_m = MAX;
    wr(5'h00, 32'd1, 1);
    wait_cyc(MAX + 6);
    rd_chk(5'h0C, 32'd2, "R3");
    wr(5'h0C, 32'd2, 2);
    wait_cyc(3);
    check(fact == '0, "R8", "fault_act after clear", 32'(fact), 32'd0);

    run_chk = 1'b0;
    summary();
    $finish;
  end

endmodule